// File: doc/BRIEF.md
# Pipelined Converter Back-End Alignment and Code Merge

This block is the digital end of a four-stage pipelined analog-to-digital converter. Every clock each analog stage hands over a 4-bit decision code. Each stage works one sample behind the stage before it, so the four codes that belong to one analog sample arrive on four different clock edges. The block puts the earlier codes through short register chains so that one sample's four codes meet in the same cycle. It then adds them with a 3-bit shift between neighbouring stages, so that the one redundant bit of each stage overlaps the next stage. It removes the constant bias that the mid-range centring of every stage adds and clamps the result to 12 bits.

The final word is offset binary. Zero is negative full scale, 0xFFF is positive full scale and 0x800 is the first code above mid-scale. It is registered onto the output bus a fixed number of clocks after the first stage's code, and each later clock brings the next word. A valid flag marks the words that were built entirely from codes taken after reset. The end-to-end latency is a parameter. When it is larger than the alignment depth, registers are added after the merge.

Top module: `pipe_adc_backend`

## Requirements
- R1: When reset is high at a clock edge, every alignment register is cleared by that edge and the output register takes `word_o` = 0x800 with `word_valid_o` = 0.
- R2: Lane m (m = 1..4) sits on `stage_codes_i[4m-1:4m-4]`. The code of lane m for a sample is captured m-1 edges after the lane-1 code of that sample. The merged word for the sample appears on `word_o` right after the LATENCY-th edge (default 3) following the lane-1 capture edge. Each further edge presents the next sample's word, and an input held constant gives a constant output.
- R3: The merged value is 512*B1 + 64*B2 + 8*B3 + B4 - 2340, where B1..B4 are the aligned lane codes. Codes (8,4,4,4) give 0x800 and codes (4,4,4,4) give 0x000.
- R4: Lane codes built from an ideal 12-bit value are reproduced exactly, including codes where a stage decision is off by ±1 and the next stage's code absorbs a compensating ∓8.
- R5: A merged value below zero is output as 0x000. It does not wrap.
- R6: A merged value above 4095 is output as 0xFFF. A value of exactly 4095 is also 0xFFF, and all-15 codes give 0xFFF.
- R7: `word_valid_o` stays low through reset and rises right after the (LATENCY+1)-th edge with reset low, the first word built only from post-reset codes. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| stage_codes_i | input | 16 | Four 4-bit stage codes, lane 1 in bits 3:0 up to lane 4 in bits 15:12 |
| word_o | output | 12 | Registered offset-binary result |
| word_valid_o | output | 1 | High when `word_o` comes from a fully post-reset sample |

## Verification
The hardest case to reach is a sample whose stage decisions are off by one and then corrected downstream. Such a sample only stays in range when the residue lies near a decision boundary of the stage. The bench draws ideal values at random and tries random ±1 errors for each stage. It keeps an error set only when every lane code stays within 0..15 and otherwise falls back to error-free codes. The lanes are skewed exactly as the pipeline would deliver them, so every check also tests alignment across different neighbouring samples. Directed codes place the merged sum one below, exactly at and one past both clamp limits.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
package adc_corr_pkg;

   // bit offset of a lane in the merged sum; lane 0 is the most significant
   function automatic int lane_shift(input int lane, input int lanes, input int step);
      return step * (lanes - 1 - lane);
   endfunction

   // total bias added by centring every lane code on mid-range
   function automatic int bias_total(input int lanes, input int step, input int center);
      int acc;
      acc = 0;
      for (int i = 0; i < lanes; i++) begin
         acc += center << (step * i);
      end
      return acc;
   endfunction

endpackage

// File: rtl/lane_delay.sv
`timescale 1ns/1ps
module lane_delay #(
   parameter int W     = 4,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] tap_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) tap_q[i] <= '0;
      end else begin
         tap_q[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) tap_q[i] <= tap_q[i-1];
      end
   end

   assign q_o = tap_q[DEPTH-1];
endmodule

// File: rtl/code_merge.sv
`timescale 1ns/1ps
module code_merge #(
   parameter int LANES  = 4,
   parameter int CODE_W = 4,
   parameter int STEP   = 3,
   parameter int OUT_W  = 12,
   parameter int BIAS   = 2340
) (
   input  logic [LANES*CODE_W-1:0] lanes_i,
   output logic [OUT_W-1:0]        word_o
);
   localparam int SUM_W   = OUT_W + CODE_W;
   localparam int OUT_MAX = (1 << OUT_W) - 1;

   logic [SUM_W-1:0] raw;
   logic [SUM_W-1:0] diff;

   always_comb begin
      raw = '0;
      for (int i = 0; i < LANES; i++) begin
         raw = raw + (SUM_W'(lanes_i[i*CODE_W +: CODE_W])
                      << adc_corr_pkg::lane_shift(i, LANES, STEP));
      end
      diff = raw - SUM_W'(BIAS);
      if (raw < SUM_W'(BIAS)) begin
         word_o = '0;
      end else if (diff > SUM_W'(OUT_MAX)) begin
         word_o = '1;
      end else begin
         word_o = diff[OUT_W-1:0];
      end
   end
endmodule

// File: rtl/out_stage.sv
`timescale 1ns/1ps
module out_stage #(
   parameter int OUT_W = 12,
   parameter int EXTRA = 0,
   parameter logic [OUT_W-1:0] RESET_WORD = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OUT_W-1:0] word_i,
   input  logic             vld_i,
   output logic [OUT_W-1:0] word_o,
   output logic             vld_o
);
   logic [OUT_W-1:0] wq [EXTRA+1];
   logic [EXTRA:0]   vq;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i <= EXTRA; i++) wq[i] <= RESET_WORD;
         vq <= '0;
      end else begin
         wq[0] <= word_i;
         vq[0] <= vld_i;
         for (int i = 1; i <= EXTRA; i++) begin
            wq[i] <= wq[i-1];
            vq[i] <= vq[i-1];
         end
      end
   end

   assign word_o = wq[EXTRA];
   assign vld_o  = vq[EXTRA];
endmodule

// File: rtl/pipe_adc_backend.sv
`timescale 1ns/1ps
module pipe_adc_backend #(
   parameter int NUM_STAGES = 4,
   parameter int CODE_W     = 4,
   parameter int STEP_BITS  = 3,
   parameter int OUT_W      = 12,
   parameter int LATENCY    = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_STAGES*CODE_W-1:0] stage_codes_i,
   output logic [OUT_W-1:0]           word_o,
   output logic                       word_valid_o
);
   localparam int ALIGN_MAX = NUM_STAGES - 1;
   localparam int EXTRA     = LATENCY - ALIGN_MAX;
   localparam int CENTER    = 1 << (CODE_W - 2);
   localparam int BIAS      = adc_corr_pkg::bias_total(NUM_STAGES, STEP_BITS, CENTER);
   localparam logic [OUT_W-1:0] MID_WORD = OUT_W'(1) << (OUT_W - 1);

   if (NUM_STAGES < 2) begin : g_bad_stages
      $error("pipe_adc_backend: NUM_STAGES must be at least 2");
   end
   if (LATENCY < ALIGN_MAX) begin : g_bad_latency
      $error("pipe_adc_backend: LATENCY below alignment depth");
   end
   if (CODE_W != STEP_BITS + 1) begin : g_bad_code
      $error("pipe_adc_backend: CODE_W must carry one redundant bit");
   end
   if (OUT_W != STEP_BITS * NUM_STAGES) begin : g_bad_out
      $error("pipe_adc_backend: OUT_W does not match stage weights");
   end

   logic [NUM_STAGES*CODE_W-1:0] aligned;
   logic [OUT_W-1:0]             merged;
   logic                         vld_token;

   for (genvar g = 0; g < NUM_STAGES; g++) begin : g_lane
      localparam int DLY = ALIGN_MAX - g;
      if (DLY > 0) begin : g_dly
         lane_delay #(.W(CODE_W), .DEPTH(DLY)) u_dly (
            .clk (clk),
            .rst (rst),
            .d_i (stage_codes_i[g*CODE_W +: CODE_W]),
            .q_o (aligned[g*CODE_W +: CODE_W])
         );
      end else begin : g_direct
         assign aligned[g*CODE_W +: CODE_W] = stage_codes_i[g*CODE_W +: CODE_W];
      end
   end

   // valid token rides the same depth as lane 1
   lane_delay #(.W(1), .DEPTH(ALIGN_MAX)) u_vld_dly (
      .clk (clk),
      .rst (rst),
      .d_i (1'b1),
      .q_o (vld_token)
   );

   code_merge #(
      .LANES  (NUM_STAGES),
      .CODE_W (CODE_W),
      .STEP   (STEP_BITS),
      .OUT_W  (OUT_W),
      .BIAS   (BIAS)
   ) u_merge (
      .lanes_i (aligned),
      .word_o  (merged)
   );

   out_stage #(
      .OUT_W      (OUT_W),
      .EXTRA      (EXTRA),
      .RESET_WORD (MID_WORD)
   ) u_out (
      .clk    (clk),
      .rst    (rst),
      .word_i (merged),
      .vld_i  (vld_token),
      .word_o (word_o),
      .vld_o  (word_valid_o)
   );
endmodule

// File: rtl/pipe_adc_backend_chk.sv
`timescale 1ns/1ps
module pipe_adc_backend_chk #(
   parameter int NUM_STAGES = 4,
   parameter int CODE_W     = 4,
   parameter int OUT_W      = 12,
   parameter int LATENCY    = 3
) (
   input logic                         clk,
   input logic                         rst,
   input logic [NUM_STAGES*CODE_W-1:0] stage_codes_i,
   input logic [OUT_W-1:0]             word_o,
   input logic                         word_valid_o
);
   localparam int RUN_MAX  = LATENCY + 2;
   localparam int FILL_MAX = LATENCY + 1;
   localparam int CNT_W    = $clog2(RUN_MAX + 2) + 1;
   localparam logic [OUT_W-1:0] MID_WORD = OUT_W'(1) << (OUT_W - 1);

   logic [NUM_STAGES*CODE_W-1:0] prev_q;
   logic                         seen_q;
   logic [CNT_W-1:0]             run_q;
   logic [CNT_W-1:0]             fill_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= '0;
         seen_q <= 1'b0;
         run_q  <= '0;
         fill_q <= '0;
      end else begin
         prev_q <= stage_codes_i;
         seen_q <= 1'b1;
         if (seen_q && (stage_codes_i == prev_q)) begin
            if (run_q != CNT_W'(RUN_MAX)) run_q <= run_q + 1'b1;
         end else begin
            run_q <= '0;
         end
         if (fill_q != CNT_W'(FILL_MAX)) fill_q <= fill_q + 1'b1;
      end
   end

   p_reset_mid_r1: assert property (@(posedge clk)
      rst |=> (word_o == MID_WORD && !word_valid_o));

   p_settle_r2: assert property (@(posedge clk) disable iff (rst)
      (run_q >= CNT_W'(RUN_MAX)) |-> $stable(word_o));

   p_clamp_low_r5: assert property (@(posedge clk) disable iff (rst)
      (run_q >= CNT_W'(RUN_MAX) && prev_q == '0) |-> (word_o == '0));

   p_clamp_high_r6: assert property (@(posedge clk) disable iff (rst)
      (run_q >= CNT_W'(RUN_MAX) && prev_q == '1) |-> (word_o == '1));

   p_fill_r7: assert property (@(posedge clk) disable iff (rst)
      word_valid_o == (fill_q >= CNT_W'(FILL_MAX)));

   p_valid_hold_r7: assert property (@(posedge clk) disable iff (rst)
      word_valid_o |=> word_valid_o);
endmodule

bind pipe_adc_backend pipe_adc_backend_chk #(
   .NUM_STAGES (NUM_STAGES),
   .CODE_W     (CODE_W),
   .OUT_W      (OUT_W),
   .LATENCY    (LATENCY)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .stage_codes_i (stage_codes_i),
   .word_o        (word_o),
   .word_valid_o  (word_valid_o)
);

// File: tb/pipe_adc_backend_bench.sv
`timescale 1ns/1ps
module pipe_adc_backend_bench;
   localparam int NS    = 4;
   localparam int CW    = 4;
   localparam int OW    = 12;
   localparam int LAT   = 3;
   localparam int NSAMP = 600;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NS*CW-1:0] codes = '0;
   logic [OW-1:0] word;
   logic          vld;

   pipe_adc_backend u_pipe_adc_backend (
      .clk           (clk),
      .rst           (rst),
      .stage_codes_i (codes),
      .word_o        (word),
      .word_valid_o  (vld)
   );

   always #2.5 clk = ~clk;

   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;
   int    smp_code [NSAMP][NS];
   int    smp_exp  [NSAMP];
   string smp_tag  [NSAMP];

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R3 formula with R5/R6 clamping
   function automatic int formula(input int c0, input int c1, input int c2, input int c3);
      int raw;
      raw = c0 * 512 + c1 * 64 + c2 * 8 + c3 - 2340;
      if (raw < 0) return 0;
      if (raw > 4095) return 4095;
      return raw;
   endfunction

   task automatic put_raw(input int idx, input int c0, input int c1, input int c2,
                          input int c3, input string tag);
      smp_code[idx][0] = c0; smp_code[idx][1] = c1;
      smp_code[idx][2] = c2; smp_code[idx][3] = c3;
      smp_exp[idx] = formula(c0, c1, c2, c3);
      smp_tag[idx] = tag;
   endtask

   // R4: stage codes with compensated ±1 decision errors
   task automatic put_ideal(input int idx, input int dval);
      int d [4];
      int e [3];
      int b [4];
      bit ok;
      for (int k = 0; k < 4; k++) d[k] = (dval >> (9 - 3 * k)) & 7;
      for (int t = 0; t < 6; t++) begin
         for (int k = 0; k < 3; k++) e[k] = (t == 5) ? 0 : int'($urandom_range(2, 0)) - 1;
         b[0] = d[0] + 4 + e[0];
         b[1] = d[1] + 4 + e[1] - 8 * e[0];
         b[2] = d[2] + 4 + e[2] - 8 * e[1];
         b[3] = d[3] + 4 - 8 * e[2];
         ok = 1'b1;
         for (int k = 0; k < 4; k++) if (b[k] < 0 || b[k] > 15) ok = 1'b0;
         if (ok) break;
      end
      for (int k = 0; k < 4; k++) smp_code[idx][k] = b[k];
      smp_exp[idx] = dval;
      smp_tag[idx] = "R4 ideal";
   endtask

   task automatic drive_edge(input int e);
      for (int m = 0; m < NS; m++) begin
         int idx;
         idx = e - 1 - m;
         codes[m*CW +: CW] = (idx >= 0 && idx < NSAMP) ? CW'(smp_code[idx][m]) : '0;
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd5804));
      put_raw(0, 8, 4, 4, 4, "R3 midscale");
      put_raw(1, 4, 4, 4, 4, "R3 zero");
      put_raw(2, 4, 4, 4, 3, "R5 one below");
      put_raw(3, 0, 0, 0, 0, "R5 all zero");
      put_raw(4, 12, 4, 4, 3, "R6 exact top");
      put_raw(5, 12, 4, 4, 4, "R6 one above");
      put_raw(6, 15, 15, 15, 15, "R6 all ones");
      put_raw(7, 7, 15, 0, 15, "R3 mixed");
      put_ideal(8, 0);
      put_ideal(9, 4095);
      put_ideal(10, 2047);
      for (int i = 11; i < 320; i++) put_ideal(i, int'($urandom_range(4095, 0)));
      for (int i = 320; i < NSAMP; i++)
         put_raw(i, int'($urandom_range(15, 0)), int'($urandom_range(15, 0)),
                 int'($urandom_range(15, 0)), int'($urandom_range(15, 0)), "R2 skewed");

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset word", int'(word), 32'h800);
      check("R1 reset valid", int'(vld), 0);

      rst = 1'b0;
      for (int e = 1; e <= NSAMP + LAT; e++) begin
         drive_edge(e);
         @(posedge clk);
         @(negedge clk);
         if (e <= LAT + 3) check("R7 fill", int'(vld), (e >= LAT + 1) ? 1 : 0);
         if (e >= LAT + 1) begin
            check(smp_tag[e - 1 - LAT], int'(word), smp_exp[e - 1 - LAT]);
         end
      end

      // R1 again mid-stream, then R7 refill with a held mid-scale input
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1 rerun word", int'(word), 32'h800);
      check("R1 rerun valid", int'(vld), 0);
      rst = 1'b0;
      codes = {4'd4, 4'd4, 4'd4, 4'd8};
      for (int e = 1; e <= LAT + 2; e++) begin
         @(posedge clk);
         @(negedge clk);
         check("R7 refill", int'(vld), (e >= LAT + 1) ? 1 : 0);
      end
      check("R3 held midscale", int'(word), 32'h800);
      finish_run();
   end
endmodule